// File: doc/BRIEF.md
# PCM Serial Clock and Frame-Sync Generator

This block produces the timing for a PCM audio port that always drives the bus as master. It sources both the serial bit clock and the frame-sync pulse. The source clocks are modelled as single-cycle enables on the system clock `clk_i`. A select input picks either the peripheral-bus tick or the audio-bus tick.

The chosen tick stream passes through two dividers in cascade. The first is a half-period divider: it turns `bclk_div_i` into the bit clock. The second counts bit periods against `sync_div_i` to place the frame sync. Both divider fields are held in shadow registers. These shadows reload only when a frame ends, so a frame is never cut short.

The clock runs when the serial-clock enable is set and at least one of these holds:
- a transfer is active;
- continuous idle mode is selected.

Otherwise the block is idle. Idle is either an unwanted stop in gated mode or a stop on request. While idle, the bit clock sits at its idle level and both counters are cleared. A data path can use `bclk_edge_o` to launch each new bit.

Top module: `pcm_clkgen`

## Requirements
- R1: When `src_sel_i`=1, the ticks come from `bus_tick_i`. Each bit period lasts exactly 2*(D+1) of those ticks, where D is the bit-clock divider in effect. Each half of the period lasts D+1 ticks.
- R2: One frame lasts S+1 bit periods, where S is the sync divider in effect.
- R3: After reset the dividers in effect are D=0 and S=127. The first frame after reset is therefore 128 bit periods long, whatever the divider inputs are.
- R4: When `src_sel_i`=0, the ticks come from `audio_tick_i` instead. Bit and frame lengths follow the same rules as R1 and R2 in those ticks.
- R5: The block runs only when `sclk_en_i` & (`xfer_active_i` | `idle_run_i`) is true.
  - Whenever that is false, in the cycle after the next clock edge: `bclk_o`=1, `fsync_o`=0 and `bclk_edge_o`=0.
  - A restart begins a fresh frame with its first bit one cycle after the run condition returns.
- R6: `bclk_o` has inverted polarity. It is low for the first half of every bit period and high for the second half. It is high while idle and during reset.
- R7: `fsync_o` is active high. It rises together with the first bit of each frame and stays high for exactly one bit period.
- R8: A new value on `bclk_div_i` or `sync_div_i` does not alter the frame in progress. The value present at a frame boundary governs the frame that starts there.
- R9: `bclk_edge_o` pulses for one cycle in each cycle where `bclk_o` falls. This marks the start of every bit, including the first bit after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_tick_i | input | 1 | Peripheral-bus source clock enable |
| audio_tick_i | input | 1 | Audio-bus source clock enable |
| src_sel_i | input | 1 | Source select: 1 selects the bus tick, 0 selects the audio tick |
| sclk_en_i | input | 1 | Serial clock enable |
| xfer_active_i | input | 1 | A transfer is in progress |
| idle_run_i | input | 1 | Continuous mode: 1 keeps the clock running while idle |
| bclk_div_i | input | 9 | Bit-clock half-period divider D |
| sync_div_i | input | 9 | Frame length in bit periods, minus one (S) |
| bclk_o | output | 1 | Bit clock, inverted polarity |
| fsync_o | output | 1 | Frame sync, active high |
| bclk_edge_o | output | 1 | One-cycle strobe at the start of each bit |

## Verification
The bench measures behaviour at the ports, frame by frame:
- the spacing between bit strobes;
- the number of strobes per frame;
- how long `fsync_o` is high;
- how long `bclk_o` is low.

A wrong half-period count or bit count shows up within one frame. It appears either as a shifted strobe interval or as a wrong number of strobes between frame-sync rises. A shadow register that loads at the wrong moment shows up in the frame during which a divider was changed: that frame takes the wrong length. A wrong source select stretches or shrinks every bit by the ratio of the two tick rates.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;
  localparam int unsigned DIV_W          = 9;
  localparam int unsigned RST_FRAME_BITS = 128;

  typedef enum logic {
    SRC_AUDIO = 1'b0,
    SRC_BUS   = 1'b1
  } src_e;
endpackage

// File: rtl/pcm_src_sel.sv
module pcm_src_sel
  import pcm_clkgen_pkg::*;
(
  input  logic bus_tick_i,
  input  logic audio_tick_i,
  input  src_e sel_i,
  output logic tick_o
);
  always_comb begin
    unique case (sel_i)
      SRC_BUS: tick_o = bus_tick_i;
      default: tick_o = audio_tick_i;
    endcase
  end
endmodule

// File: rtl/pcm_bclk_div.sv
module pcm_bclk_div #(
  parameter int unsigned DIV_W = pcm_clkgen_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_start_o,
  output logic             first_o,
  output logic             bclk_o,
  output logic             edge_o
);
  logic             active_q, phase_q, start_q;
  logic [DIV_W-1:0] half_cnt_q;
  logic             half_wrap;

  assign half_wrap   = tick_i && (half_cnt_q == div_i);
  assign bit_start_o = run_i && (!active_q || (half_wrap && phase_q));
  assign first_o     = !active_q;
  // inverted clock: low in first half, high in second, high when idle
  assign bclk_o      = !active_q || phase_q;
  assign edge_o      = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      phase_q    <= 1'b0;
      start_q    <= 1'b0;
      half_cnt_q <= '0;
    end else if (!run_i) begin
      active_q   <= 1'b0;
      phase_q    <= 1'b0;
      start_q    <= 1'b0;
      half_cnt_q <= '0;
    end else if (!active_q) begin
      active_q   <= 1'b1;
      phase_q    <= 1'b0;
      start_q    <= 1'b1;
      half_cnt_q <= '0;
    end else begin
      start_q <= bit_start_o;
      if (tick_i) begin
        if (half_wrap) begin
          half_cnt_q <= '0;
          phase_q    <= !phase_q;
        end else begin
          half_cnt_q <= half_cnt_q + 1'b1;
        end
      end
    end
  end

  AST_HALF_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_cnt_q <= div_i); // R1

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o); // R9

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (bclk_o && !edge_o && half_cnt_q == '0)); // R5
endmodule

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl #(
  parameter int unsigned DIV_W          = pcm_clkgen_pkg::DIV_W,
  parameter int unsigned RST_FRAME_BITS = pcm_clkgen_pkg::RST_FRAME_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bit_start_i,
  input  logic             first_i,
  input  logic [DIV_W-1:0] bclk_div_i,
  input  logic [DIV_W-1:0] sync_div_i,
  output logic [DIV_W-1:0] bclk_div_o,
  output logic             fsync_o
);
  localparam logic [DIV_W-1:0] RST_SYNC_DIV = DIV_W'(RST_FRAME_BITS - 1);

  logic [DIV_W-1:0] bit_cnt_q, sdiv_q, bdiv_q;
  logic             fsync_q;
  logic             frame_wrap;

  assign frame_wrap = bit_start_i && !first_i && (bit_cnt_q == sdiv_q);
  assign bclk_div_o = bdiv_q;
  assign fsync_o    = fsync_q;

  // shadow dividers reload only at a frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdiv_q <= RST_SYNC_DIV;
      bdiv_q <= '0;
    end else if (run_i && frame_wrap) begin
      sdiv_q <= sync_div_i;
      bdiv_q <= bclk_div_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      fsync_q   <= 1'b0;
    end else if (!run_i) begin
      bit_cnt_q <= '0;
      fsync_q   <= 1'b0;
    end else if (bit_start_i) begin
      if (first_i || frame_wrap) begin
        bit_cnt_q <= '0;
        fsync_q   <= 1'b1;
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        fsync_q   <= 1'b0;
      end
    end
  end

  AST_BIT_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= sdiv_q); // R2

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_wrap |=> ($stable(sdiv_q) && $stable(bdiv_q))); // R8

  AST_FSYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bit_start_i) |=> $stable(fsync_q)); // R7
endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
  import pcm_clkgen_pkg::*;
#(
  parameter int unsigned DIV_W          = pcm_clkgen_pkg::DIV_W,
  parameter int unsigned RST_FRAME_BITS = pcm_clkgen_pkg::RST_FRAME_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_tick_i,
  input  logic             audio_tick_i,
  input  logic             src_sel_i,
  input  logic             sclk_en_i,
  input  logic             xfer_active_i,
  input  logic             idle_run_i,
  input  logic [DIV_W-1:0] bclk_div_i,
  input  logic [DIV_W-1:0] sync_div_i,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic             bclk_edge_o
);
  logic             run, tick, bit_start, first;
  logic [DIV_W-1:0] bdiv_eff;

  // gated mode stops the clock when idle, continuous mode keeps it running
  assign run = sclk_en_i && (xfer_active_i || idle_run_i);

  pcm_src_sel u_src (
    .bus_tick_i  (bus_tick_i),
    .audio_tick_i(audio_tick_i),
    .sel_i       (src_e'(src_sel_i)),
    .tick_o      (tick)
  );

  pcm_bclk_div #(.DIV_W(DIV_W)) u_bclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .div_i      (bdiv_eff),
    .bit_start_o(bit_start),
    .first_o    (first),
    .bclk_o     (bclk_o),
    .edge_o     (bclk_edge_o)
  );

  pcm_frame_ctrl #(.DIV_W(DIV_W), .RST_FRAME_BITS(RST_FRAME_BITS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .bit_start_i(bit_start),
    .first_i    (first),
    .bclk_div_i (bclk_div_i),
    .sync_div_i (sync_div_i),
    .bclk_div_o (bdiv_eff),
    .fsync_o    (fsync_o)
  );

  AST_FALL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) |-> bclk_edge_o); // R9

  AST_FSYNC_ON_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fsync_o) |-> (bclk_edge_o && !bclk_o)); // R7

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_en_i |=> (bclk_o && !fsync_o)); // R5
endmodule

// File: tb/pcm_clkgen_tb_top.sv
`timescale 1ns/1ps
module pcm_clkgen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       bus_tick, audio_tick, src_sel, sclk_en, xfer_active, idle_run;
  logic [8:0] bdiv, sdiv;
  logic       bclk, fsync, bedge;
  int unsigned tick_cnt = 0;
  int total = 0, bad = 0;

  assign bus_tick   = 1'b1;
  assign audio_tick = (tick_cnt % 3 == 0);
  always @(negedge clk) tick_cnt <= tick_cnt + 1;

  pcm_clkgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_tick_i(bus_tick), .audio_tick_i(audio_tick),
    .src_sel_i(src_sel), .sclk_en_i(sclk_en), .xfer_active_i(xfer_active),
    .idle_run_i(idle_run), .bclk_div_i(bdiv), .sync_div_i(sdiv),
    .bclk_o(bclk), .fsync_o(fsync), .bclk_edge_o(bedge)
  );

  // {src, bclk_div, sync_div}
  localparam logic [18:0] VEC [0:5] = '{
    {1'b1, 9'd0,   9'd7},
    {1'b1, 9'd3,   9'd3},
    {1'b0, 9'd1,   9'd15},
    {1'b1, 9'd0,   9'd1},
    {1'b0, 9'd0,   9'd1},
    {1'b1, 9'd511, 9'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    bit pf;
    pf = fsync;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (fsync && !pf) return;
      pf = fsync;
    end
    chk(1'b0, "R7 frame sync never rose", 0, 1);
  endtask

  // starts on a rise sample, ends on the next rise sample
  task automatic measure(input int exp_bit, input bit chg, input logic [8:0] nb,
                         input logic [8:0] ns, output int cyc, output int edges,
                         output int hi, output int lo, output int gaps);
    int last;
    bit pf;
    cyc = 0; edges = 0; hi = 0; lo = 0; gaps = 0; last = 0;
    while (1) begin
      if (bedge) begin
        edges++;
        if (cyc > 0 && (cyc - last) != exp_bit) gaps++;
        if (bclk) gaps++;
        last = cyc;
      end
      hi += int'(fsync);
      lo += int'(!bclk);
      if (chg && cyc == 3) begin
        bdiv = nb;
        sdiv = ns;
      end
      pf = fsync;
      cyc++;
      @(negedge clk);
      if (fsync && !pf) break;
      if (cyc > 20000) break;
    end
  endtask

  initial begin
    #500000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, edges, hi, lo, gaps, n, ob, os;
    logic vs;
    logic [8:0] vb, vsd;
    src_sel = 1'b1; sclk_en = 1'b1; xfer_active = 1'b0; idle_run = 1'b1;
    bdiv = 9'd0; sdiv = 9'd7;
    repeat (4) @(negedge clk);
    chk(bclk == 1'b1, "R6 reset bclk level", int'(bclk), 1);
    chk(fsync == 1'b0, "R5 reset fsync", int'(fsync), 0);
    chk(bedge == 1'b0, "R9 reset strobe", int'(bedge), 0);
    rst_n = 1'b1;

    // R3: first frame uses reset shadows (128 bits, D=0)
    wait_rise();
    measure(2, 1'b0, 9'd0, 9'd0, cyc, edges, hi, lo, gaps);
    chk(edges == 128, "R3 bits in first frame", edges, 128);
    chk(cyc == 256, "R3 first frame cycles", cyc, 256);
    measure(2, 1'b0, 9'd0, 9'd0, cyc, edges, hi, lo, gaps);
    chk(edges == 8, "R8 loaded at boundary", edges, 8);
    chk(cyc == 16, "R2 frame cycles", cyc, 16);

    ob = 0; os = 7;
    for (int i = 0; i < 6; i++) begin
      {vs, vb, vsd} = VEC[i];
      n = vs ? 1 : 3;
      src_sel = vs;
      wait_rise();
      measure(2 * (ob + 1) * n, 1'b1, vb, vsd, cyc, edges, hi, lo, gaps);
      chk(cyc == (os + 1) * 2 * (ob + 1) * n, "R8 frame with mid change", cyc,
          (os + 1) * 2 * (ob + 1) * n);
      chk(edges == os + 1, "R8 bits with mid change", edges, os + 1);
      measure(2 * (vb + 1) * n, 1'b0, 9'd0, 9'd0, cyc, edges, hi, lo, gaps);
      chk(cyc == (vsd + 1) * 2 * (vb + 1) * n, vs ? "R1 frame cycles" : "R4 frame cycles",
          cyc, (vsd + 1) * 2 * (vb + 1) * n);
      chk(edges == vsd + 1, "R2 bits per frame", edges, vsd + 1);
      chk(hi == 2 * (vb + 1) * n, "R7 fsync high cycles", hi, 2 * (vb + 1) * n);
      chk(lo == (vsd + 1) * (vb + 1) * n, "R6 bclk low cycles", lo, (vsd + 1) * (vb + 1) * n);
      chk(gaps == 0, vs ? "R1 strobe spacing" : "R4 strobe spacing", gaps, 0);
      ob = vb; os = vsd;
    end

    // R5: gated mode stops the clock while no transfer is active
    wait_rise();
    idle_run = 1'b0; xfer_active = 1'b0;
    @(negedge clk);
    chk(bclk == 1'b1 && fsync == 1'b0, "R5 idle after gate", int'({bclk, fsync}), 2);
    edges = 0; hi = 0; lo = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      edges += int'(bedge); hi += int'(fsync); lo += int'(!bclk);
    end
    chk(edges + hi + lo == 0, "R5 gated idle activity", edges + hi + lo, 0);
    xfer_active = 1'b1;
    @(negedge clk);
    chk(bedge == 1'b1, "R9 strobe on restart", int'(bedge), 1);
    chk(fsync == 1'b1, "R7 fsync on restart", int'(fsync), 1);
    chk(bclk == 1'b0, "R6 bclk low at bit start", int'(bclk), 0);
    measure(2 * (ob + 1), 1'b0, 9'd0, 9'd0, cyc, edges, hi, lo, gaps);
    chk(edges == os + 1 && gaps == 0, "R5 fresh frame after restart", edges, os + 1);

    // R5: enable low overrides continuous mode
    idle_run = 1'b1; sclk_en = 1'b0;
    @(negedge clk);
    edges = 0; lo = 0; hi = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      edges += int'(bedge); lo += int'(!bclk); hi += int'(fsync);
    end
    chk(edges + lo + hi == 0, "R5 enable off activity", edges + lo + hi, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule